// File: doc/BRIEF.md
# Peripheral Bridge Access-Permission Filter

This block stands between an AHB-style slave port and a simple two-phase peripheral bus that fans out to several peripheral selects. Each transfer that arrives carries a master number, a read/write flag, a privileged attribute, a non-secure attribute and a peripheral index. The block looks up two 4-bit permission fields for that transfer: one held for the requesting master and one held for the target peripheral. A permitted transfer runs as a setup cycle and then an access cycle on the peripheral bus. The supervisor signal driven with it comes from the privileged attribute, after the master's field has had a chance to force it down to user level. A forbidden transfer never reaches the peripheral bus. It ends upstream with the standard two-cycle error response.

The permission fields live in a small set of 32-bit configuration registers, each holding eight fields. They return to their reset defaults on every reset, so system code must reprogram them before masters use the peripherals. A write to the register port takes effect for the next address phase that is accepted.

Top module: `bpf_filter`

## Requirements
- R1: After reset every master field and every peripheral field holds its default value (0 with the default parameters), so both configuration registers read 0. The upstream port shows ready high with an OKAY response, and no peripheral select is active.
- R2: Register address 0 holds the master fields and address 1 holds the peripheral fields. Field n sits in bits [31-4n:28-4n], so index 0 is in the top nibble. Nibbles that belong to no master or peripheral read as 0 and ignore writes. Reads are combinational from `cfg_addr`.
- R3: A permitted transfer gives a setup cycle (one-hot select for the indexed peripheral, enable low, upstream ready low), then an access cycle (select and enable high, ready high, OKAY, read data taken from `p_rdata`), then the peripheral bus goes idle. The peripheral write data follows `s_hwdata`.
- R4: A peripheral whose field is 0000 accepts every transfer, whatever the master's field and the attributes.
- R5: When bit 2 of the peripheral field is set, a transfer passes the supervisor check only if the privileged attribute is 1 and bit 0 of the master's field is 1.
- R6: The supervisor signal on the peripheral bus equals the privileged attribute when bit 0 of the master field is 1, and is 0 when that bit is 0.
- R7: When bit 1 of the peripheral field is set, writes are rejected and reads are not affected by that bit.
- R8: When bit 0 of the peripheral field is set, transfers with the non-secure attribute high are rejected.
- R9: For a peripheral whose field is nonzero, a write needs bit 2 of the master field and a read needs bit 1 of the master field. Otherwise the transfer is rejected.
- R10: A rejected transfer drives error with ready low for one cycle, then error with ready high for one cycle, and raises no peripheral select during either cycle.
- R11: A new address phase offered in the access cycle or in the second error cycle is accepted at once. Its setup or first error cycle follows directly, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_hsel | input | 1 | Slave select |
| s_htrans | input | 2 | Transfer type; 10 or 11 marks a valid address phase |
| s_hwrite | input | 1 | 1 for write |
| s_hmaster | input | MID_W (2) | Requesting master number |
| s_hpriv | input | 1 | Privileged attribute (1 = supervisor) |
| s_hnonsec | input | 1 | Non-secure attribute |
| s_hperiph | input | PIDX_W (3) | Target peripheral index |
| s_hwdata | input | DATA_W | Write data (data phase) |
| s_hrdata | output | DATA_W | Read data |
| s_hready | output | 1 | Transfer done / ready for address |
| s_hresp | output | 1 | 1 = ERROR response |
| p_sel | output | NUM_PERIPH | One-hot peripheral select |
| p_enable | output | 1 | Access-phase enable |
| p_write | output | 1 | Peripheral write flag |
| p_super | output | 1 | Supervisor level of the access |
| p_wdata | output | DATA_W | Peripheral write data |
| p_rdata | input | DATA_W | Peripheral read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (1) | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
The hardest cases to reach are pipelined ones, where a new address phase overlaps the completion of the previous transfer. To get there, the bench offers a denied address during an access cycle, and then a permitted address during the second cycle of the error that results. It then checks that the error and the following setup each start on the very next edge. A second hard point is the supervisor rule, because it depends on three things at once: the peripheral's required bit, the master's privilege-pass bit and the attribute on the bus. The register values are chosen so that each of these, alone, is the reason for a rejection. The bench also reprograms one master between transfers, to show that a new field value takes effect on the next transfer.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

   localparam int PERM_W      = 4;
   localparam int NIB_PER_REG = 8;

   // peripheral field bits
   localparam int PF_NSDENY = 0;
   localparam int PF_WPROT  = 1;
   localparam int PF_SUPREQ = 2;

   // master field bits
   localparam int MF_PRIVPASS = 0;
   localparam int MF_RDTRUST  = 1;
   localparam int MF_WRTRUST  = 2;

   typedef logic [PERM_W-1:0] perm_nib_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ACCESS,
      ST_ERR1,
      ST_ERR2
   } bpf_state_e;

endpackage

// File: rtl/bpf_cfg_regs.sv
module bpf_cfg_regs
   import bpf_pkg::*;
#(
   parameter int        NUM_MASTERS = 4,
   parameter int        NUM_PERIPH  = 8,
   parameter int        CFG_AW      = 1,
   parameter perm_nib_t MST_RST     = 4'h0,
   parameter perm_nib_t PER_RST     = 4'h0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [CFG_AW-1:0]                 cfg_addr,
   input  logic [31:0]                       cfg_wdata,
   output logic [31:0]                       cfg_rdata,
   output logic [NUM_MASTERS-1:0][PERM_W-1:0] mst_perm,
   output logic [NUM_PERIPH-1:0][PERM_W-1:0]  per_perm
);

   localparam int MREGS = (NUM_MASTERS + NIB_PER_REG - 1) / NIB_PER_REG;

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
      localparam logic [CFG_AW-1:0] RADDR = CFG_AW'(m / NIB_PER_REG);
      localparam int LSB = 28 - 4 * (m % NIB_PER_REG);
      perm_nib_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= MST_RST;
         else if (cfg_we && cfg_addr == RADDR)
            q <= cfg_wdata[LSB +: PERM_W];
      end
      assign mst_perm[m] = q;
   end

   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
      localparam logic [CFG_AW-1:0] RADDR = CFG_AW'(MREGS + p / NIB_PER_REG);
      localparam int LSB = 28 - 4 * (p % NIB_PER_REG);
      perm_nib_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= PER_RST;
         else if (cfg_we && cfg_addr == RADDR)
            q <= cfg_wdata[LSB +: PERM_W];
      end
      assign per_perm[p] = q;
   end

   always_comb begin
      cfg_rdata = '0;
      for (int m = 0; m < NUM_MASTERS; m++) begin
         if (cfg_addr == CFG_AW'(m / NIB_PER_REG))
            cfg_rdata[28 - 4 * (m % NIB_PER_REG) +: PERM_W] = mst_perm[m];
      end
      for (int p = 0; p < NUM_PERIPH; p++) begin
         if (cfg_addr == CFG_AW'(MREGS + p / NIB_PER_REG))
            cfg_rdata[28 - 4 * (p % NIB_PER_REG) +: PERM_W] = per_perm[p];
      end
   end

endmodule

// File: rtl/bpf_perm_check.sv
module bpf_perm_check
   import bpf_pkg::*;
#(
   parameter bit TRUST_EN = 1'b1
) (
   input  perm_nib_t mst_field,
   input  perm_nib_t per_field,
   input  logic      is_write,
   input  logic      priv,
   input  logic      nonsec,
   output logic      allow,
   output logic      super_lvl
);

   logic trust_ok;

   // The trust bits can be left out of the decision when a system does not need them.
   if (TRUST_EN) begin : g_trust
      assign trust_ok = is_write ? mst_field[MF_WRTRUST] : mst_field[MF_RDTRUST];
   end else begin : g_no_trust
      assign trust_ok = 1'b1;
   end

   assign super_lvl = priv & mst_field[MF_PRIVPASS];

   always_comb begin
      if (per_field == '0) begin
         allow = 1'b1;
      end else begin
         allow = trust_ok
               & ~(per_field[PF_SUPREQ] & ~super_lvl)
               & ~(per_field[PF_WPROT]  & is_write)
               & ~(per_field[PF_NSDENY] & nonsec);
      end
   end

endmodule

// File: rtl/bpf_xfer_seq.sv
module bpf_xfer_seq
   import bpf_pkg::*;
#(
   parameter int NUM_PERIPH = 8,
   parameter int PIDX_W     = 3,
   parameter int DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic                  allow,
   input  logic [PIDX_W-1:0]     idx,
   input  logic                  is_write,
   input  logic                  super_lvl,
   input  logic [DATA_W-1:0]     p_rdata,
   output logic [NUM_PERIPH-1:0] p_sel,
   output logic                  p_enable,
   output logic                  p_write,
   output logic                  p_super,
   output logic                  hready,
   output logic                  hresp,
   output logic [DATA_W-1:0]     hrdata
);

   bpf_state_e       st, st_nx;
   logic [PIDX_W-1:0] idx_q;
   logic              accept, busy;

   assign accept = req & hready;

   always_comb begin
      st_nx = ST_IDLE;
      case (st)
         ST_SETUP: st_nx = ST_ACCESS;
         ST_ERR1:  st_nx = ST_ERR2;
         default:  st_nx = accept ? (allow ? ST_SETUP : ST_ERR1) : ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         idx_q   <= '0;
         p_write <= 1'b0;
         p_super <= 1'b0;
      end else begin
         st <= st_nx;
         if (accept && allow) begin
            idx_q   <= idx;
            p_write <= is_write;
            p_super <= super_lvl;
         end
      end
   end

   assign busy     = (st == ST_SETUP) || (st == ST_ACCESS);
   assign p_enable = (st == ST_ACCESS);
   assign hready   = !((st == ST_SETUP) || (st == ST_ERR1));
   assign hresp    = (st == ST_ERR1) || (st == ST_ERR2);
   assign hrdata   = p_enable ? p_rdata : '0;

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_sel
      assign p_sel[i] = busy && (idx_q == PIDX_W'(i));
   end

   // R3
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(p_sel));

   // R3
   setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_enable |-> $past(|p_sel && !p_enable));

   // R3
   ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_enable |-> $stable(p_write) && $stable(p_super) && $stable(p_sel));

   // R10
   err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hready) |=> (hresp && hready));

   // R10
   err_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hresp |-> (p_sel == '0));

endmodule

// File: rtl/bpf_filter.sv
module bpf_filter
   import bpf_pkg::*;
#(
   parameter int        NUM_MASTERS = 4,
   parameter int        NUM_PERIPH  = 8,
   parameter int        DATA_W      = 32,
   parameter bit        TRUST_EN    = 1'b1,
   parameter perm_nib_t MST_RST     = 4'h0,
   parameter perm_nib_t PER_RST     = 4'h0,
   localparam int MID_W  = $clog2(NUM_MASTERS),
   localparam int PIDX_W = $clog2(NUM_PERIPH),
   localparam int NREGS  = (NUM_MASTERS + NIB_PER_REG - 1) / NIB_PER_REG
                         + (NUM_PERIPH + NIB_PER_REG - 1) / NIB_PER_REG,
   localparam int CFG_AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  s_hsel,
   input  logic [1:0]            s_htrans,
   input  logic                  s_hwrite,
   input  logic [MID_W-1:0]      s_hmaster,
   input  logic                  s_hpriv,
   input  logic                  s_hnonsec,
   input  logic [PIDX_W-1:0]     s_hperiph,
   input  logic [DATA_W-1:0]     s_hwdata,
   output logic [DATA_W-1:0]     s_hrdata,
   output logic                  s_hready,
   output logic                  s_hresp,
   output logic [NUM_PERIPH-1:0] p_sel,
   output logic                  p_enable,
   output logic                  p_write,
   output logic                  p_super,
   output logic [DATA_W-1:0]     p_wdata,
   input  logic [DATA_W-1:0]     p_rdata,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata
);

   if (NUM_MASTERS < 2 || (NUM_MASTERS & (NUM_MASTERS - 1)) != 0) begin : g_bad_nm
      $error("NUM_MASTERS must be a power of two and at least 2");
   end
   if (NUM_PERIPH < 2 || (NUM_PERIPH & (NUM_PERIPH - 1)) != 0) begin : g_bad_np
      $error("NUM_PERIPH must be a power of two and at least 2");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must be at least 8");
   end

   logic [NUM_MASTERS-1:0][PERM_W-1:0] mst_perm;
   logic [NUM_PERIPH-1:0][PERM_W-1:0]  per_perm;
   perm_nib_t mst_field, per_field;
   logic      req, accept, allow, super_lvl;

   assign req       = s_hsel && (s_htrans inside {2'b10, 2'b11});
   assign accept    = req && s_hready;
   assign mst_field = mst_perm[s_hmaster];
   assign per_field = per_perm[s_hperiph];
   assign p_wdata   = s_hwdata;

   bpf_cfg_regs #(
      .NUM_MASTERS (NUM_MASTERS),
      .NUM_PERIPH  (NUM_PERIPH),
      .CFG_AW      (CFG_AW),
      .MST_RST     (MST_RST),
      .PER_RST     (PER_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .mst_perm  (mst_perm),
      .per_perm  (per_perm)
   );

   bpf_perm_check #(
      .TRUST_EN (TRUST_EN)
   ) u_check (
      .mst_field (mst_field),
      .per_field (per_field),
      .is_write  (s_hwrite),
      .priv      (s_hpriv),
      .nonsec    (s_hnonsec),
      .allow     (allow),
      .super_lvl (super_lvl)
   );

   bpf_xfer_seq #(
      .NUM_PERIPH (NUM_PERIPH),
      .PIDX_W     (PIDX_W),
      .DATA_W     (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .allow     (allow),
      .idx       (s_hperiph),
      .is_write  (s_hwrite),
      .super_lvl (super_lvl),
      .p_rdata   (p_rdata),
      .p_sel     (p_sel),
      .p_enable  (p_enable),
      .p_write   (p_write),
      .p_super   (p_super),
      .hready    (s_hready),
      .hresp     (s_hresp),
      .hrdata    (s_hrdata)
   );

   // R4
   open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && per_field == '0) |=> (|p_sel && !s_hresp));

   // R5
   sup_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && per_field[PF_SUPREQ] && !(s_hpriv && mst_field[MF_PRIVPASS]))
      |=> (s_hresp && !s_hready));

   // R6
   forced_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !mst_field[MF_PRIVPASS]) |=> (p_sel == '0 || !p_super));

   // R8
   ns_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && per_field[PF_NSDENY] && s_hnonsec) |=> (s_hresp && p_sel == '0));

endmodule

// File: tb/bpf_filter_tb.sv
module bpf_filter_tb;

   localparam int NP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_hsel = 1'b0;
   logic [1:0]  s_htrans = 2'b00;
   logic        s_hwrite = 1'b0;
   logic [1:0]  s_hmaster = '0;
   logic        s_hpriv = 1'b0;
   logic        s_hnonsec = 1'b0;
   logic [2:0]  s_hperiph = '0;
   logic [31:0] s_hwdata = '0;
   logic [31:0] s_hrdata;
   logic        s_hready, s_hresp;
   logic [NP-1:0] p_sel;
   logic        p_enable, p_write, p_super;
   logic [31:0] p_wdata, p_rdata;
   logic        cfg_we = 1'b0;
   logic [0:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   assign p_rdata = 32'h5A5A_0000 ^ {24'h0, p_sel};

   bpf_filter u_dut (
      .clk(clk), .rst_n(rst_n), .s_hsel(s_hsel), .s_htrans(s_htrans),
      .s_hwrite(s_hwrite), .s_hmaster(s_hmaster), .s_hpriv(s_hpriv),
      .s_hnonsec(s_hnonsec), .s_hperiph(s_hperiph), .s_hwdata(s_hwdata),
      .s_hrdata(s_hrdata), .s_hready(s_hready), .s_hresp(s_hresp),
      .p_sel(p_sel), .p_enable(p_enable), .p_write(p_write), .p_super(p_super),
      .p_wdata(p_wdata), .p_rdata(p_rdata), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic drive_addr(input int m, input int p, input bit w,
                             input bit priv, input bit ns);
      s_hsel    = 1'b1;
      s_htrans  = 2'b10;
      s_hmaster = 2'(m);
      s_hperiph = 3'(p);
      s_hwrite  = w;
      s_hpriv   = priv;
      s_hnonsec = ns;
   endtask

   task automatic drive_idle();
      s_hsel   = 1'b0;
      s_htrans = 2'b00;
   endtask

   task automatic cfg_write(input bit a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input bit a, input logic [31:0] exp, input string req);
      cfg_addr = a;
      #1;
      chk(cfg_rdata == exp, req, "register readback", cfg_rdata, exp);
   endtask

   // one transfer from an idle bus; req names the rule that decides it
   task automatic xfer(input int m, input int p, input bit w, input bit priv,
                       input bit ns, input bit exp_ok, input bit exp_sup,
                       input string req);
      logic [NP-1:0] sel_exp;
      sel_exp = NP'(1) << p;
      drive_addr(m, p, w, priv, ns);
      tick();
      drive_idle();
      s_hwdata = 32'hD000_0000 | 32'(p);
      if (exp_ok) begin
         chk(p_sel == sel_exp && !s_hresp, req, "accepted to setup", 32'(p_sel), 32'(sel_exp));
         chk(!p_enable && !s_hready, "R3", "setup enable/ready", {p_enable, s_hready}, 0);
         chk(p_write == w, "R3", "write flag", 32'(p_write), 32'(w));
         chk(p_super == exp_sup, "R6", "supervisor level", 32'(p_super), 32'(exp_sup));
         tick();
         chk(p_enable && s_hready && !s_hresp && p_sel == sel_exp, "R3", "access phase",
             {p_enable, s_hready, s_hresp, 8'(p_sel)}, {3'b110, 8'(sel_exp)});
         chk(s_hrdata == (32'h5A5A_0000 ^ 32'(sel_exp)), "R3", "read data",
             s_hrdata, 32'h5A5A_0000 ^ 32'(sel_exp));
         if (w) chk(p_wdata == s_hwdata, "R3", "write data", p_wdata, s_hwdata);
         tick();
         chk(p_sel == '0 && s_hready && !p_enable, "R3", "idle after access", 32'(p_sel), 0);
      end else begin
         chk(s_hresp && !s_hready, req, "rejected, error cycle 1", {s_hresp, s_hready}, 2'b10);
         chk(p_sel == '0, "R10", "no select in error 1", 32'(p_sel), 0);
         tick();
         chk(s_hresp && s_hready && p_sel == '0, "R10", "error cycle 2",
             {s_hresp, s_hready, 8'(p_sel)}, {2'b11, 8'h0});
         tick();
         chk(!s_hresp && s_hready, "R10", "okay after error", {s_hresp, s_hready}, 2'b01);
      end
   endtask

   task automatic t_reset();
      chk(s_hready && !s_hresp && p_sel == '0, "R1", "port idle after reset",
          {s_hready, s_hresp, 8'(p_sel)}, {2'b10, 8'h0});
      cfg_read(1'b0, 32'h0, "R1");
      cfg_read(1'b1, 32'h0, "R1");
      tick();
   endtask

   task automatic t_open_default();
      xfer(3, 5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
      xfer(1, 7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
   endtask

   task automatic t_program();
      // masters: m0=7, m1=1, m2=6, m3=0; low nibbles have no master
      cfg_write(1'b0, 32'h7160_ABCD);
      // peripherals: p0=0, p1=4, p2=2, p3=1, p4=8, p5..p7=0
      cfg_write(1'b1, 32'h0421_8000);
      cfg_read(1'b0, 32'h7160_0000, "R2");
      cfg_read(1'b1, 32'h0421_8000, "R2");
   endtask

   task automatic t_open_after_prog();
      xfer(3, 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
   endtask

   task automatic t_supervisor();
      xfer(0, 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
      xfer(0, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      xfer(2, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
   endtask

   task automatic t_super_level();
      xfer(0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
      xfer(0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
      xfer(2, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
   endtask

   task automatic t_write_protect();
      xfer(0, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
      xfer(0, 2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
   endtask

   task automatic t_nonsecure();
      xfer(0, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
      xfer(0, 3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
   endtask

   task automatic t_trust();
      xfer(2, 4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
      xfer(2, 4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
      xfer(1, 4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
      xfer(1, 4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
      // m3 becomes read-trusted only
      cfg_write(1'b0, 32'h7162_0000);
      xfer(3, 4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
      xfer(3, 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
   endtask

   task automatic t_back_to_back();
      drive_addr(0, 0, 1'b0, 1'b1, 1'b0);
      tick();
      drive_idle();
      tick();
      chk(p_enable && s_hready, "R11", "access cycle open", {p_enable, s_hready}, 2'b11);
      drive_addr(0, 2, 1'b1, 1'b1, 1'b0);   // denied by write protect
      tick();
      drive_idle();
      chk(s_hresp && !s_hready && p_sel == '0, "R11", "error right after access",
          {s_hresp, s_hready, 8'(p_sel)}, {2'b10, 8'h0});
      tick();
      chk(s_hresp && s_hready, "R11", "second error cycle", {s_hresp, s_hready}, 2'b11);
      drive_addr(0, 3, 1'b0, 1'b1, 1'b0);   // permitted
      tick();
      drive_idle();
      chk(p_sel == 8'h08 && !p_enable && !s_hresp, "R11", "setup right after error",
          32'(p_sel), 32'h08);
      tick();
      chk(p_enable && s_hrdata == (32'h5A5A_0000 ^ 32'h08), "R11", "access after error",
          s_hrdata, 32'h5A5A_0008);
      tick();
      chk(p_sel == '0, "R11", "idle at end", 32'(p_sel), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      tick();
      t_reset();
      t_open_default();
      t_program();
      t_open_after_prog();
      t_supervisor();
      t_super_level();
      t_write_protect();
      t_nonsecure();
      t_trust();
      t_back_to_back();
      tick();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule